// File: doc/BRIEF.md
# Command/Address Beat Encoder

This block turns one internal memory request into the beats that travel on a 14-bit command/address bus toward a DRAM device. A request names an operation (precharge, all-bank refresh, activate, read or write) and the target chip, bank group, bank, row and column. Commands with no address go out in a single beat. Activate, read and write are split over two consecutive beats that together carry 28 bits. Chip select is raised with the first beat only.

A ready/valid handshake takes requests. A request is taken in any cycle where both are high. Ready drops for the one cycle in which the first beat of a two-beat command is on the bus, so the second beat always follows at once. Before issue, every request is screened. A read or write whose column is not a multiple of 8 is refused, because the three low column bits are never sent. A burst-chop flag on a command that moves no data is refused. An undefined opcode is refused. A refused request is consumed and raises an error strobe for one cycle. Nothing goes on the bus for it.

One spare address bit is sent in each command. A parameter chooses whether it is a fourth chip-ID bit or an eighteenth row bit.

Top module: `ca_cmd_encoder`

## Requirements
- R1: During reset and after it, `req_ready` is 1, `ca_cs` is 0, `ca_bus` is 0 and `req_err` is 0 while no request is offered.
- R2: A taken precharge (op 0) or refresh (op 1) shows its single beat in the cycle after acceptance, with `ca_cs`=1. Precharge is {x, cid[2:0], ba[1:0], bg[2:0], 5'b01011} and refresh is {x, cid[2:0], 5'b00000, 5'b10011}. The cycle after that shows `ca_bus`=0 and `ca_cs`=0 unless another request was taken.
- R3: A taken activate (op 2) shows beat 1 = {row[3:0], cid[2:0], ba, bg, 2'b00} in the cycle after acceptance and beat 2 = {y, row[16:4]} in the cycle after that.
- R4: A taken read (op 3, code 5'b11101) or write (op 4, code 5'b01101) shows beat 1 = {chop, cid[2:0], ba, bg, code} and then beat 2 = {5'b00000, x, col[10:3]}.
- R5: `ca_cs` is 1 on the first beat of a two-beat command and 0 on its second beat. `req_ready` is 0 exactly while the first beat is on the bus, and a request held valid in that cycle is taken in the next cycle.
- R6: A read or write with any of col[2:0] set is taken, raises `req_err` for one cycle in the cycle after acceptance, and leaves `ca_cs`=0 and `ca_bus`=0.
- R7: A request with an undefined opcode (5, 6 or 7), or with `req_chop`=1 on an opcode other than read or write, is refused in the same way as in R6.
- R8: With EXT_IS_CID=1, both x and y equal cid[3]. With EXT_IS_CID=0, x is 0 and y equals row[17].
- R9: Single-beat requests offered in consecutive cycles are taken in consecutive cycles, and their beats appear in consecutive cycles in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | 0 precharge, 1 refresh, 2 activate, 3 read, 4 write |
| req_cid | input | 4 | Chip ID; bit 3 is used only when the spare bit is a chip-ID bit |
| req_bg | input | 3 | Bank group |
| req_ba | input | 2 | Bank |
| req_row | input | 18 | Row; bit 17 is used only when the spare bit is a row bit |
| req_col | input | 11 | Column; bits 2..0 must be zero for read and write |
| req_chop | input | 1 | Burst chop to 8 beats instead of 16 (read and write only) |
| ca_bus | output | 14 | Command/address beat |
| ca_cs | output | 1 | Chip-select strobe, high on first beats |
| req_err | output | 1 | One-cycle strobe for a refused request |

## Verification
Precharge is swept over every chip, bank-group and bank value, so that a swapped or shifted field shows up in the beat. Activate is driven with a walking one over all 18 row bits, which isolates how the row is split between the two beats and where the spare bit lands. Read and write are driven with every one of the 2048 column values: aligned columns check the packing of col[10:3], and the misaligned ones must all be refused. Two instances that differ only in the spare-bit role see the same stimulus. Back-to-back and held-valid sequences test the handshake and the order of the beats.

// File: rtl/ca_enc_pkg.sv
package ca_enc_pkg;
  parameter int CID_W      = 3;
  parameter int BG_W       = 3;
  parameter int BA_W       = 2;
  parameter int ROW_W      = 17;
  parameter int COL_W      = 11;
  parameter int CA_W       = 14;
  parameter int OP_W       = 3;
  parameter int CODE_W     = 5;
  parameter int ACT_CODE_W = 2;
  parameter int COL_SKIP   = 3;

  localparam int COL_TX_W  = COL_W - COL_SKIP;
  localparam int ROW_LO_W  = CA_W - (ACT_CODE_W + BG_W + BA_W + CID_W);
  localparam int PAD2_W    = CA_W - COL_TX_W - 1;
  localparam int ZERO_BB_W = BA_W + BG_W;

  typedef enum logic [OP_W-1:0] {
    OP_PRE = 3'd0,
    OP_REF = 3'd1,
    OP_ACT = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4
  } cmd_op_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [CID_W:0]   cid;
    logic [BG_W-1:0]  bg;
    logic [BA_W-1:0]  ba;
    logic [ROW_W:0]   row;
    logic [COL_W-1:0] col;
    logic             chop;
  } ca_req_t;
endpackage

// File: rtl/ca_req_check.sv
module ca_req_check
  import ca_enc_pkg::*;
(
  input  ca_req_t req,
  output logic    req_bad
);
  logic col_op;
  logic known_op;
  logic misaligned;

  always_comb begin
    col_op     = (req.op == OP_RD) || (req.op == OP_WR);
    known_op   = col_op || (req.op == OP_PRE) || (req.op == OP_REF) ||
                 (req.op == OP_ACT);
    misaligned = col_op && (req.col[COL_SKIP-1:0] != '0);
    req_bad    = !known_op || misaligned || (req.chop && !col_op);
  end
endmodule

// File: rtl/ca_beat_pack.sv
module ca_beat_pack
  import ca_enc_pkg::*;
#(
  parameter logic [ACT_CODE_W-1:0] ACT_CODE   = 2'b00,
  parameter logic [CODE_W-1:0]     PRE_CODE   = 5'b01011,
  parameter logic [CODE_W-1:0]     REF_CODE   = 5'b10011,
  parameter logic [CODE_W-1:0]     RD_CODE    = 5'b11101,
  parameter logic [CODE_W-1:0]     WR_CODE    = 5'b01101,
  parameter bit                    EXT_IS_CID = 1'b0
)(
  input  ca_req_t         req,
  output logic [CA_W-1:0] beat_first,
  output logic [CA_W-1:0] beat_second,
  output logic            two_beat
);
  logic ext_cmd;
  logic ext_act;

  // spare bit: chip-ID extension everywhere, or row extension on activate
  assign ext_cmd = EXT_IS_CID ? req.cid[CID_W] : 1'b0;
  assign ext_act = EXT_IS_CID ? req.cid[CID_W] : req.row[ROW_W];

  always_comb begin
    beat_first  = '0;
    beat_second = '0;
    two_beat    = 1'b0;
    case (req.op)
      OP_PRE: beat_first = {ext_cmd, req.cid[CID_W-1:0], req.ba, req.bg, PRE_CODE};
      OP_REF: beat_first = {ext_cmd, req.cid[CID_W-1:0], {ZERO_BB_W{1'b0}}, REF_CODE};
      OP_ACT: begin
        beat_first  = {req.row[ROW_LO_W-1:0], req.cid[CID_W-1:0], req.ba, req.bg,
                       ACT_CODE};
        beat_second = {ext_act, req.row[ROW_W-1:ROW_LO_W]};
        two_beat    = 1'b1;
      end
      OP_RD, OP_WR: begin
        beat_first  = {req.chop, req.cid[CID_W-1:0], req.ba, req.bg,
                       (req.op == OP_RD) ? RD_CODE : WR_CODE};
        beat_second = {{PAD2_W{1'b0}}, ext_cmd, req.col[COL_W-1:COL_SKIP]};
        two_beat    = 1'b1;
      end
      default: begin
        beat_first  = '0;
        beat_second = '0;
        two_beat    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ca_beat_seq.sv
module ca_beat_seq
  import ca_enc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_bad,
  input  logic [CA_W-1:0] beat_first,
  input  logic [CA_W-1:0] beat_second,
  input  logic            two_beat,
  output logic            req_ready,
  output logic [CA_W-1:0] ca_q,
  output logic            cs_q,
  output logic            err_q
);
  typedef enum logic {S_IDLE, S_TAIL} seq_state_e;

  seq_state_e      state_q, state_n;
  logic [CA_W-1:0] tail_q;
  logic [CA_W-1:0] ca_n;
  logic            cs_n, err_n, tail_en, accept;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign tail_en   = accept && !req_bad && two_beat;

  always_comb begin
    state_n = S_IDLE;
    ca_n    = '0;
    cs_n    = 1'b0;
    err_n   = 1'b0;
    if (state_q == S_TAIL) begin
      ca_n = tail_q;
    end else if (accept) begin
      if (req_bad) begin
        err_n = 1'b1;
      end else begin
        ca_n = beat_first;
        cs_n = 1'b1;
        if (two_beat) state_n = S_TAIL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ca_q    <= '0;
      cs_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ca_q    <= ca_n;
      cs_q    <= cs_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (tail_en) begin
      tail_q <= beat_second;
    end
  end
endmodule

// File: rtl/ca_cmd_encoder.sv
module ca_cmd_encoder
  import ca_enc_pkg::*;
#(
  parameter logic [ACT_CODE_W-1:0] ACT_CODE   = 2'b00,
  parameter logic [CODE_W-1:0]     PRE_CODE   = 5'b01011,
  parameter logic [CODE_W-1:0]     REF_CODE   = 5'b10011,
  parameter logic [CODE_W-1:0]     RD_CODE    = 5'b11101,
  parameter logic [CODE_W-1:0]     WR_CODE    = 5'b01101,
  parameter bit                    EXT_IS_CID = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OP_W-1:0]  req_op,
  input  logic [CID_W:0]   req_cid,
  input  logic [BG_W-1:0]  req_bg,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W:0]   req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_chop,
  output logic [CA_W-1:0]  ca_bus,
  output logic             ca_cs,
  output logic             req_err
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  ca_req_t         req;
  logic            req_bad;
  logic [CA_W-1:0] beat_first, beat_second;
  logic            two_beat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req = '{op: req_op, cid: req_cid, bg: req_bg, ba: req_ba,
                 row: req_row, col: req_col, chop: req_chop};

  ca_req_check u_check (
    .req     (req),
    .req_bad (req_bad)
  );

  ca_beat_pack #(
    .ACT_CODE   (ACT_CODE),
    .PRE_CODE   (PRE_CODE),
    .REF_CODE   (REF_CODE),
    .RD_CODE    (RD_CODE),
    .WR_CODE    (WR_CODE),
    .EXT_IS_CID (EXT_IS_CID)
  ) u_pack (
    .req         (req),
    .beat_first  (beat_first),
    .beat_second (beat_second),
    .two_beat    (two_beat)
  );

  ca_beat_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_bad     (req_bad),
    .beat_first  (beat_first),
    .beat_second (beat_second),
    .two_beat    (two_beat),
    .req_ready   (req_ready),
    .ca_q        (ca_bus),
    .cs_q        (ca_cs),
    .err_q       (req_err)
  );
endmodule

// File: rtl/ca_cmd_encoder_chk.sv
module ca_cmd_encoder_chk
  import ca_enc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OP_W-1:0]  req_op,
  input logic [COL_W-1:0] req_col,
  input logic             req_chop,
  input logic [CA_W-1:0]  ca_bus,
  input logic             ca_cs,
  input logic             req_err
);
  logic taken;
  assign taken = req_valid && req_ready;

  // R5: ready is low only while a first beat with chip select is on the bus
  a_r5_ready_low_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> ca_cs);

  // R5: the second beat follows without chip select and ready returns
  a_r5_tail_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready && !ca_cs));

  // R6: a refusal leaves the bus quiet
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!ca_cs && ca_bus == '0));

  // R6: misaligned read or write is refused
  a_r6_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (req_op == 3'd3 || req_op == 3'd4) && req_col[COL_SKIP-1:0] != '0)
    |=> (req_err && !ca_cs));

  // R7: undefined opcode is refused
  a_r7_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && req_op > 3'd4) |=> (req_err && !ca_cs));

  // R2: a valid precharge is issued in the next cycle
  a_r2_pre_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && req_op == 3'd0 && !req_chop) |=> (ca_cs && !req_err));
endmodule

bind ca_cmd_encoder ca_cmd_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_col   (req_col),
  .req_chop  (req_chop),
  .ca_bus    (ca_bus),
  .ca_cs     (ca_cs),
  .req_err   (req_err)
);

// File: tb/ca_cmd_encoder_test.sv
module ca_cmd_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [3:0]  req_cid;
  logic [2:0]  req_bg;
  logic [1:0]  req_ba;
  logic [17:0] req_row;
  logic [10:0] req_col;
  logic        req_chop;
  logic        req_ready, ca_cs, req_err;
  logic [13:0] ca_bus;
  logic        rdy_x, cs_x, err_x;
  logic [13:0] bus_x;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ca_cmd_encoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cid(req_cid), .req_bg(req_bg), .req_ba(req_ba),
    .req_row(req_row), .req_col(req_col), .req_chop(req_chop),
    .ca_bus(ca_bus), .ca_cs(ca_cs), .req_err(req_err));

  ca_cmd_encoder #(.EXT_IS_CID(1'b1)) uut_cid (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_x),
    .req_op(req_op), .req_cid(req_cid), .req_bg(req_bg), .req_ba(req_ba),
    .req_row(req_row), .req_col(req_col), .req_chop(req_chop),
    .ca_bus(bus_x), .ca_cs(cs_x), .req_err(err_x));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] exp_first(int op, logic [3:0] cid, logic [2:0] bg,
      logic [1:0] ba, logic [17:0] row, logic chop, bit xc);
    logic x;
    x = xc ? cid[3] : 1'b0;
    case (op)
      0: return {x, cid[2:0], ba, bg, 5'b01011};
      1: return {x, cid[2:0], 5'b00000, 5'b10011};
      2: return {row[3:0], cid[2:0], ba, bg, 2'b00};
      3: return {chop, cid[2:0], ba, bg, 5'b11101};
      4: return {chop, cid[2:0], ba, bg, 5'b01101};
      default: return 14'h0;
    endcase
  endfunction

  function automatic logic [13:0] exp_second(int op, logic [3:0] cid, logic [17:0] row,
      logic [10:0] col, bit xc);
    if (op == 2) return {xc ? cid[3] : row[17], row[16:4]};
    return {5'b00000, xc ? cid[3] : 1'b0, col[10:3]};
  endfunction

  task automatic drive(int op, int cid, int bg, int ba, int row, int col, int chop);
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_cid   = 4'(cid);
    req_bg    = 3'(bg);
    req_ba    = 2'(ba);
    req_row   = 18'(row);
    req_col   = 11'(col);
    req_chop  = 1'(chop);
  endtask

  task automatic send(string tag, int op, int cid, int bg, int ba, int row, int col,
      int chop);
    bit col_op, bad, two;
    logic [13:0] e1, e1x, e2, e2x;
    col_op = (op == 3 || op == 4);
    bad = (op > 4) || (col_op && (col % 8) != 0) || (chop != 0 && !col_op);
    two = !bad && op >= 2 && op <= 4;
    e1  = exp_first(op, 4'(cid), 3'(bg), 2'(ba), 18'(row), 1'(chop), 1'b0);
    e1x = exp_first(op, 4'(cid), 3'(bg), 2'(ba), 18'(row), 1'(chop), 1'b1);
    e2  = exp_second(op, 4'(cid), 18'(row), 11'(col), 1'b0);
    e2x = exp_second(op, 4'(cid), 18'(row), 11'(col), 1'b1);
    @(negedge clk);
    drive(op, cid, bg, ba, row, col, chop);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      check({tag, " err"}, req_err, 1);
      check({tag, " err cs"}, ca_cs, 0);
      check({tag, " err bus"}, ca_bus, 0);
      check({tag, " err alt"}, err_x, 1);
    end else begin
      check({tag, " cs first"}, ca_cs, 1);
      check({tag, " beat1"}, ca_bus, e1);
      check({tag, " R8 beat1 cid-ext"}, bus_x, e1x);
      check({tag, " R5 ready"}, req_ready, two ? 0 : 1);
    end
    @(negedge clk);
    if (two) begin
      check({tag, " beat2"}, ca_bus, e2);
      check({tag, " R8 beat2 cid-ext"}, bus_x, e2x);
      check({tag, " R5 cs second"}, ca_cs, 0);
      check({tag, " R5 ready back"}, req_ready, 1);
    end else begin
      check({tag, " idle bus"}, ca_bus, 0);
      check({tag, " idle cs"}, ca_cs, 0);
      check({tag, " err clear"}, req_err, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ready in reset", req_ready, 1);
    check("R1 cs in reset", ca_cs, 0);
    check("R1 bus in reset", ca_bus, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 err after reset", req_err, 0);

    // R2: precharge over every chip, group and bank
    for (int c = 0; c < 16; c++)
      for (int g = 0; g < 8; g++)
        for (int b = 0; b < 4; b++)
          send("R2 pre", 0, c, g, b, 0, 0, 0);
    // R2: refresh ignores bank fields
    for (int c = 0; c < 16; c++) send("R2 ref", 1, c, 7 - (c % 8), c % 4, 0, 0, 0);

    // R3/R8: activate with walking-one rows and all-ones row
    for (int i = 0; i < 18; i++) send("R3 act", 2, i % 16, i % 8, i % 4, 1 << i, 0, 0);
    send("R3 act ones", 2, 15, 7, 3, 18'h3ffff, 0, 0);
    send("R3 act zero", 2, 0, 0, 0, 0, 0, 0);

    // R4/R6: every column for read and write
    for (int op = 3; op <= 4; op++)
      for (int c = 0; c < 2048; c++)
        send((c % 8 == 0) ? "R4 col" : "R6 misaligned", op, c % 16, (c >> 4) % 8,
             (c >> 7) % 4, 0, c, (c >> 3) % 2);

    // R7: undefined opcodes and chop on non-column commands
    for (int op = 5; op < 8; op++) send("R7 bad op", op, 3, 2, 1, 5, 0, 0);
    for (int op = 0; op < 3; op++) send("R7 chop", op, 3, 2, 1, 5, 0, 1);

    // R9: back-to-back single beats
    @(negedge clk);
    drive(0, 1, 2, 3, 0, 0, 0);
    @(negedge clk);
    check("R9 ready b2b", req_ready, 1);
    drive(1, 6, 0, 0, 0, 0, 0);
    check("R9 first beat", ca_bus, exp_first(0, 4'd1, 3'd2, 2'd3, 18'd0, 1'b0, 1'b0));
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 second cs", ca_cs, 1);
    check("R9 second beat", ca_bus, exp_first(1, 4'd6, 3'd0, 2'd0, 18'd0, 1'b0, 1'b0));
    @(negedge clk);
    check("R9 idle", ca_cs, 0);

    // R5: request held valid while ready is low
    @(negedge clk);
    drive(3, 2, 5, 1, 0, 16, 0);
    @(negedge clk);
    check("R5 held ready low", req_ready, 0);
    check("R5 held beat1", ca_bus, exp_first(3, 4'd2, 3'd5, 2'd1, 18'd0, 1'b0, 1'b0));
    drive(0, 4, 1, 2, 0, 0, 0);
    @(negedge clk);
    check("R5 held beat2", ca_bus, exp_second(3, 4'd2, 18'd0, 11'd16, 1'b0));
    check("R5 held cs low", ca_cs, 0);
    check("R5 held ready high", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 held next cs", ca_cs, 1);
    check("R5 held next beat", ca_bus, exp_first(0, 4'd4, 3'd1, 2'd2, 18'd0, 1'b0, 1'b0));
    @(negedge clk);
    check("R5 held idle", ca_bus, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule